// File: doc/BRIEF.md
# Tamper Monitor Security State Controller

This block keeps the security state of a battery-backed secure unit. Ten tamper event inputs (supply voltage, clock, temperature, secure-controller alarm, external boot, external line A, external line B, wire mesh, time-counter overflow and monotonic-counter overflow) are latched into sticky event flags. Each event also has an enable bit in a tamper configuration register. An event whose enable bit is set raises the security-violation flag. The unit then sits in the failure state, and a freeze output holds the counters elsewhere in the unit.

The unit has three conditions. Not-valid always follows a battery reset. Failure follows any enabled event. Valid means neither flag is set. A system reset in the failure state moves the unit to failure plus not-valid, where software can recover it. Recovery has a fixed order: zero the tamper enables, clear the event flags, clear the violation flag, and clear the not-valid flag last.

Software lock bits protect the configuration. Soft locks are released by a system reset. Hard locks are released only by a battery reset. Registers are written through a simple write strobe with a two-bit register select. The state is read back on parallel outputs.

Top module: `tamper_guard`

## Requirements
- R1: While `bat_rst_n` is low and after it rises, the state is as follows. `status_o` = 32'h0000_0002, meaning the not-valid flag (bit 1) is set and the violation flag (bit 0) is clear. All event flags, `tcfg_o`, `ctrl_o` and the interrupt enable are zero.
- R2: `freeze_o` is high whenever the violation flag or the not-valid flag is set, and it is low only in the valid state.
- R3: Event input `evt_i[i]` uses enable bit `tcfg_o[i]`. The indices are 0 voltage, 1 clock, 2 temperature, 3 secure-controller alarm, 4 external boot, 5 external A, 6 external B, 7 wire mesh, 8 time overflow and 9 monotonic overflow. An event with its enable bit set raises the violation flag on the next clock edge.
- R4: Every event latches its status flag whether or not it is enabled. The flags sit at status bits 16+i for i in 0..7, bit 2 for time overflow and bit 3 for monotonic overflow. A disabled event does not raise the violation flag.
- R5: A write with `wr_sel_i`=0 loads `wr_data_i[9:0]` into the tamper configuration. The write is ignored while the configuration soft lock (`ctrl_o[29]`) or hard lock (`ctrl_o[30]`) is set.
- R6: A write with `wr_sel_i`=1 sets control lock bits 30, 29 and 16 wherever the data holds a 1. Writing 0 never clears a lock. A system reset clears only bit 29. Bits 30 and 16 clear only on a battery reset.
- R7: A status write (`wr_sel_i`=2) with bit 0 set clears the violation flag. The clear is ignored unless the not-valid flag is set and no event flag with its enable bit set remains.
- R8: A status write with bit 1 set clears the not-valid flag. The clear is ignored while the violation flag is set.
- R9: A `sys_rst_i` pulse taken while the violation flag is set sets the not-valid flag, unless the failure hard lock (`ctrl_o[16]`) is set. If that lock is set, the not-valid flag is left unchanged. A register write in the same cycle as `sys_rst_i` is ignored.
- R10: `sv_irq_o` is high exactly when interrupt enable bit 0 (written with `wr_sel_i`=3) and the violation flag are both set.
- R11: A status write clears each event flag whose status bit holds a 1. An event arriving in the same cycle keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst_n | input | 1 | Battery reset, asynchronous, active low |
| sys_rst_i | input | 1 | System reset pulse, synchronous, active high |
| evt_i | input | 10 | Tamper event inputs, index order as in R3 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 configuration, 1 control, 2 status clear, 3 interrupt enable |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Event flags, not-valid flag and violation flag |
| tcfg_o | output | 10 | Tamper configuration enables |
| ctrl_o | output | 32 | Lock bits 30, 29 and 16 |
| irq_en_o | output | 1 | Violation interrupt enable |
| freeze_o | output | 1 | Counter stop |
| sv_irq_o | output | 1 | Violation interrupt |

## Verification
The assertions check on every cycle that an enabled event always raises the violation flag one edge later and that an event always leaves its flag set. They also check that a violation or not-valid clear happens only when its guard allows it, that the configuration stays stable under a lock, and that hard locks never fall. The bench scenarios are needed for the parts that span several writes. These are the full recovery order, the release of the soft lock by a system reset, the failure hard lock blocking that reset, and the exact status encodings and reset values seen at the ports.

// File: rtl/tamper_guard_pkg.sv
package tamper_guard_pkg;
    localparam int EVT_N   = 10;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = 2;

    localparam int ST_SVF        = 0;
    localparam int ST_NVF        = 1;
    localparam int CTL_CFG_HARD  = 30;
    localparam int CTL_CFG_SOFT  = 29;
    localparam int CTL_FAIL_HARD = 16;

    typedef enum logic [SEL_W-1:0] {
        SEL_TCFG = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_IRQ  = 2'd3
    } reg_sel_e;

    // status bit position of event index i
    function automatic int evt_pos(input int i);
        return (i < 8) ? (16 + i) : (i - 6);
    endfunction
endpackage

// File: rtl/tamper_evt_latch.sv
module tamper_evt_latch #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         bat_rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] tcfg_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o,
    output logic         trig_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign trig_o  = |(evt_i & tcfg_i);
    assign pend_o  = |(st_q.flags & tcfg_i);

    // R4 / R11: an arriving event always leaves its flag set
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/tamper_lock_regs.sv
module tamper_lock_regs #(
    parameter int N      = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              bat_rst_n,
    input  logic              sys_rst_i,
    input  logic              wr_tcfg_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_irq_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [N-1:0]      tcfg_o,
    output logic              cfg_soft_o,
    output logic              cfg_hard_o,
    output logic              fail_hard_o,
    output logic              irq_en_o
);
    import tamper_guard_pkg::*;

    typedef struct packed {
        logic [N-1:0] tcfg;
        logic         cfg_soft;
        logic         cfg_hard;
        logic         fail_hard;
        logic         irq_en;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_tcfg_i && !st_q.cfg_soft && !st_q.cfg_hard)
            st_d.tcfg = data_i[N-1:0];
        if (wr_ctrl_i) begin
            st_d.cfg_soft  = st_q.cfg_soft  | data_i[CTL_CFG_SOFT];
            st_d.cfg_hard  = st_q.cfg_hard  | data_i[CTL_CFG_HARD];
            st_d.fail_hard = st_q.fail_hard | data_i[CTL_FAIL_HARD];
        end
        if (wr_irq_i)
            st_d.irq_en = data_i[0];
        if (sys_rst_i)
            st_d.cfg_soft = 1'b0;
    end

    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign tcfg_o      = st_q.tcfg;
    assign cfg_soft_o  = st_q.cfg_soft;
    assign cfg_hard_o  = st_q.cfg_hard;
    assign fail_hard_o = st_q.fail_hard;
    assign irq_en_o    = st_q.irq_en;

    // R5: configuration frozen under either lock
    p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (cfg_soft_o || cfg_hard_o) |=> $stable(tcfg_o));
    // R6: hard locks never fall before a battery reset
    p_hard_sticky_r6: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (cfg_hard_o && fail_hard_o) |=> (cfg_hard_o && fail_hard_o));
    p_cfg_hard_sticky_r6: assert property (@(posedge clk) disable iff (!bat_rst_n)
        cfg_hard_o |=> cfg_hard_o);
endmodule

// File: rtl/tamper_state_ctl.sv
module tamper_state_ctl (
    input  logic clk,
    input  logic bat_rst_n,
    input  logic sys_rst_i,
    input  logic trig_i,
    input  logic pend_i,
    input  logic fail_hard_i,
    input  logic clr_svf_i,
    input  logic clr_nvf_i,
    output logic svf_o,
    output logic nvf_o,
    output logic freeze_o
);
    typedef struct packed {
        logic svf;
        logic nvf;
    } sec_st_t;

    sec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i)
            st_d.svf = 1'b1;
        else if (clr_svf_i && st_q.nvf && !pend_i)
            st_d.svf = 1'b0;

        if (sys_rst_i && st_q.svf && !fail_hard_i)
            st_d.nvf = 1'b1;
        else if (clr_nvf_i && !st_q.svf)
            st_d.nvf = 1'b0;
    end

    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n) st_q <= '{svf: 1'b0, nvf: 1'b1};
        else            st_q <= st_d;
    end

    assign svf_o    = st_q.svf;
    assign nvf_o    = st_q.nvf;
    assign freeze_o = st_q.svf | st_q.nvf;

    // R3: enabled event enters failure on the next edge
    p_trig_fail_r3: assert property (@(posedge clk) disable iff (!bat_rst_n)
        trig_i |=> svf_o);
    // R7: violation clears only from not-valid with nothing enabled pending
    p_svf_guard_r7: assert property (@(posedge clk) disable iff (!bat_rst_n)
        $fell(svf_o) |-> $past(nvf_o && !pend_i && clr_svf_i));
    // R8: not-valid never clears while violation is set
    p_nvf_guard_r8: assert property (@(posedge clk) disable iff (!bat_rst_n)
        $fell(nvf_o) |-> $past(!svf_o));
    // R9: a failure hard lock keeps a system reset from raising not-valid
    p_fail_lock_r9: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (sys_rst_i && fail_hard_i && !nvf_o) |=> !nvf_o);
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tamper_guard_pkg::*;
#(
    parameter int N      = EVT_N,
    parameter int DW     = DATA_W
) (
    input  logic              clk,
    input  logic              bat_rst_n,
    input  logic              sys_rst_i,
    input  logic [N-1:0]      evt_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [DW-1:0]     status_o,
    output logic [N-1:0]      tcfg_o,
    output logic [DW-1:0]     ctrl_o,
    output logic              irq_en_o,
    output logic              freeze_o,
    output logic              sv_irq_o
);
    logic         wr_ok, wr_tcfg, wr_ctrl, wr_stat, wr_irq;
    logic [N-1:0] clr_mask, flags;
    logic         trig, pend, svf, nvf;
    logic         cfg_soft, cfg_hard, fail_hard;

    // system reset takes priority over any register write (R9)
    assign wr_ok   = wr_en_i && !sys_rst_i;
    assign wr_tcfg = wr_ok && (wr_sel_i == SEL_TCFG);
    assign wr_ctrl = wr_ok && (wr_sel_i == SEL_CTRL);
    assign wr_stat = wr_ok && (wr_sel_i == SEL_STAT);
    assign wr_irq  = wr_ok && (wr_sel_i == SEL_IRQ);

    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr_mask[g] = wr_stat && wr_data_i[evt_pos(g)];
    end

    tamper_evt_latch #(.N(N)) u_evt (
        .clk       (clk),
        .bat_rst_n (bat_rst_n),
        .evt_i     (evt_i),
        .tcfg_i    (tcfg_o),
        .clr_i     (clr_mask),
        .flags_o   (flags),
        .trig_o    (trig),
        .pend_o    (pend)
    );

    tamper_lock_regs #(.N(N), .DATA_W(DW)) u_lock (
        .clk         (clk),
        .bat_rst_n   (bat_rst_n),
        .sys_rst_i   (sys_rst_i),
        .wr_tcfg_i   (wr_tcfg),
        .wr_ctrl_i   (wr_ctrl),
        .wr_irq_i    (wr_irq),
        .data_i      (wr_data_i),
        .tcfg_o      (tcfg_o),
        .cfg_soft_o  (cfg_soft),
        .cfg_hard_o  (cfg_hard),
        .fail_hard_o (fail_hard),
        .irq_en_o    (irq_en_o)
    );

    tamper_state_ctl u_state (
        .clk         (clk),
        .bat_rst_n   (bat_rst_n),
        .sys_rst_i   (sys_rst_i),
        .trig_i      (trig),
        .pend_i      (pend),
        .fail_hard_i (fail_hard),
        .clr_svf_i   (wr_stat && wr_data_i[ST_SVF]),
        .clr_nvf_i   (wr_stat && wr_data_i[ST_NVF]),
        .svf_o       (svf),
        .nvf_o       (nvf),
        .freeze_o    (freeze_o)
    );

    always_comb begin
        status_o         = '0;
        status_o[ST_SVF] = svf;
        status_o[ST_NVF] = nvf;
        for (int i = 0; i < N; i++)
            status_o[evt_pos(i)] = flags[i];
    end

    always_comb begin
        ctrl_o                = '0;
        ctrl_o[CTL_CFG_HARD]  = cfg_hard;
        ctrl_o[CTL_CFG_SOFT]  = cfg_soft;
        ctrl_o[CTL_FAIL_HARD] = fail_hard;
    end

    assign sv_irq_o = irq_en_o & svf;

    // R2: counters stopped whenever not in the valid state
    p_freeze_r2: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (status_o[ST_SVF] || status_o[ST_NVF]) |-> freeze_o);
endmodule

// File: tb/tamper_guard_bench.sv
module tamper_guard_bench;
    logic        clk = 1'b0;
    logic        bat_rst_n = 1'b0;
    logic        sys_rst_i = 1'b0;
    logic [9:0]  evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] status_o, ctrl_o;
    logic [9:0]  tcfg_o;
    logic        irq_en_o, freeze_o, sv_irq_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    tamper_guard u_tamper_guard (
        .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst_i(sys_rst_i), .evt_i(evt_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .tcfg_o(tcfg_o), .ctrl_o(ctrl_o),
        .irq_en_o(irq_en_o), .freeze_o(freeze_o), .sv_irq_o(sv_irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic pulse_evt(input logic [9:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic pulse_sys();
        @(negedge clk);
        sys_rst_i = 1'b1;
        @(negedge clk);
        sys_rst_i = 1'b0;
    endtask

    task automatic t_battery_reset();
        @(negedge clk);
        bat_rst_n = 1'b0;
        @(negedge clk);
        bat_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status_o, 32'h2);
        chk("R1 tcfg", {22'd0, tcfg_o}, 32'h0);
        chk("R1 ctrl", ctrl_o, 32'h0);
        chk("R1 irq_en", {31'd0, irq_en_o}, 32'h0);
        chk("R2 freeze in not-valid", {31'd0, freeze_o}, 32'h1);
    endtask

    task automatic t_leave_not_valid();
        wr(2'd2, 32'h2);
        chk("R8 nvf cleared", status_o, 32'h0);
        chk("R2 freeze low when valid", {31'd0, freeze_o}, 32'h0);
    endtask

    task automatic t_disabled_events();
        pulse_evt(10'h080);   // wire mesh
        chk("R4 wire flag bit23", status_o, 32'h0080_0000);
        pulse_evt(10'h200);   // monotonic overflow
        chk("R4 mono flag bit3", status_o, 32'h0080_0008);
        chk("R4 no freeze", {31'd0, freeze_o}, 32'h0);
        wr(2'd2, 32'h0080_0008);
        chk("R11 w1c flags", status_o, 32'h0);
    endtask

    task automatic t_clear_race();
        @(negedge clk);
        evt_i = 10'h004; wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 32'h0004_0000;
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
        chk("R11 event wins over clear", status_o, 32'h0004_0000);
        wr(2'd2, 32'h0004_0000);
        chk("R11 temp flag cleared", status_o, 32'h0);
    endtask

    task automatic t_enabled_event();
        wr(2'd3, 32'h1);
        wr(2'd0, 32'h1);
        chk("R5 tcfg write", {22'd0, tcfg_o}, 32'h1);
        chk("R10 no irq when valid", {31'd0, sv_irq_o}, 32'h0);
        pulse_evt(10'h001);
        chk("R3 violation raised", status_o, 32'h0001_0001);
        chk("R2 freeze in failure", {31'd0, freeze_o}, 32'h1);
        chk("R10 irq", {31'd0, sv_irq_o}, 32'h1);
        wr(2'd2, 32'h0001_0000);
        wr(2'd2, 32'h1);
        chk("R7 clear ignored without nvf", status_o, 32'h1);
    endtask

    task automatic t_soft_lock_and_sys_reset();
        wr(2'd1, 32'h2000_0000);
        chk("R6 soft lock set", ctrl_o, 32'h2000_0000);
        wr(2'd0, 32'h0);
        chk("R5 tcfg locked", {22'd0, tcfg_o}, 32'h1);
        wr(2'd1, 32'h0);
        chk("R6 zero write keeps lock", ctrl_o, 32'h2000_0000);
        pulse_sys();
        chk("R9 sys reset adds nvf", status_o, 32'h3);
        chk("R6 soft lock released", ctrl_o, 32'h0);
    endtask

    task automatic t_recovery_order();
        pulse_evt(10'h001);
        chk("R4 flag relatched", status_o, 32'h0001_0003);
        wr(2'd2, 32'h1);
        chk("R7 clear ignored while enabled flag pending", status_o, 32'h0001_0003);
        wr(2'd2, 32'h2);
        chk("R8 nvf clear ignored in failure", status_o, 32'h0001_0003);
        wr(2'd0, 32'h0);
        chk("R5 tcfg zeroed", {22'd0, tcfg_o}, 32'h0);
        wr(2'd2, 32'h0001_0000);
        chk("R11 flag cleared", status_o, 32'h3);
        wr(2'd2, 32'h1);
        chk("R7 violation cleared", status_o, 32'h2);
        chk("R10 irq dropped", {31'd0, sv_irq_o}, 32'h0);
        wr(2'd2, 32'h2);
        chk("R8 back to valid", status_o, 32'h0);
        chk("R2 freeze released", {31'd0, freeze_o}, 32'h0);
    endtask

    task automatic t_hard_locks();
        wr(2'd0, 32'h200);
        wr(2'd1, 32'h4001_0000);
        chk("R6 hard locks set", ctrl_o, 32'h4001_0000);
        wr(2'd0, 32'h3FF);
        chk("R5 tcfg hard locked", {22'd0, tcfg_o}, 32'h200);
        pulse_evt(10'h200);
        chk("R3 mono overflow failure", status_o, 32'h9);
        @(negedge clk);
        sys_rst_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 32'h8;
        @(negedge clk);
        sys_rst_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
        chk("R9 fail hard lock blocks nvf, write dropped", status_o, 32'h9);
        chk("R6 hard locks survive sys reset", ctrl_o, 32'h4001_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_battery_reset();
        t_leave_not_valid();
        t_disabled_events();
        t_clear_race();
        t_enabled_event();
        t_soft_lock_and_sys_reset();
        t_recovery_order();
        t_hard_locks();
        t_battery_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule